// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Programmable Bit Rate

This block is a minimal asynchronous serial transmitter and receiver wired straight to a pair of chip pins. It has no external transceiver logic. Software reaches it through two 32-bit words. The first is a divider word that sets how many system clocks one bit lasts. The second is a data word: writing it sends a byte, and reading it collects a received byte.

Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. The receiver keeps a single byte. Reading the data word hands back that byte and empties the buffer. When nothing is waiting, the read returns a word with every bit set, so software can poll the data word without a separate status word.

A write to the data word that arrives while a frame is still going out holds the bus with a wait signal until the transmitter is free.

Top module: `mmio_uart`

## Requirements
- R1: The divider word is a full 32-bit read/write register. A write with `div_we_i` high shows the written value on `div_rdata_o` from the next cycle.
- R2: The bit period in clocks is the divider value, with values below 4 treated as 4.
- R3: `tx_o` idles high. An accepted data write sends `data[7:0]` as one low start bit, then bits 0 to 7, then one high stop bit, each lasting one bit period and starting at the clock edge that accepts the write.
- R4: While a frame is being sent, a data write raises `dat_wait_o` and is not taken. It is accepted at the first edge after the transmitter frees, which is 10 bit periods after the previous accepted write.
- R5: After a frame is received, `dat_rdata_o` reads `{24'h0, byte}`.
- R6: When the receive buffer is empty, including after reset, `dat_rdata_o` reads 32'hFFFFFFFF.
- R7: A read (`dat_re_i` high for one cycle) empties the buffer, so the next read returns 32'hFFFFFFFF.
- R8: The receiver starts on a high-to-low change of `rx_i` and samples every bit near its middle. It drops any frame whose stop bit is low, and it still accepts later frames.
- R9: A newly received byte overwrites an unread older byte.
- R10: Reset (`rst_ni` low) leaves `tx_o` high, the divider at its reset value of 16, and the receive buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Write strobe for the divider word |
| div_wdata_i | input | 32 | Divider write value |
| div_rdata_o | output | 32 | Current divider value |
| dat_we_i | input | 1 | Write strobe for the data word (starts a frame) |
| dat_re_i | input | 1 | Read strobe for the data word (empties the buffer) |
| dat_wdata_i | input | 32 | Byte to send in bits 7:0 |
| dat_rdata_o | output | 32 | Received byte, zero-extended, or all ones when empty |
| dat_wait_o | output | 1 | Holds a data write while the transmitter is busy |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |

## Verification
The assertions on the read path assume that a read strobe lasts one cycle and is not held across a stall. The receive checks assume that the divider stays constant during a frame. The stimulus changes the divider only while both directions are idle. Every strobe is a single negative-edge pulse. Serial input is either the transmit line looped back, or frames the bench drives with whole bit periods at the active divider.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx #(
  parameter int DIV_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  period_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_CW  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [BIT_CW-1:0]  left_q;
  logic [DIV_W-1:0]   cnt_q;
  logic               busy_q;
  logic               tick;

  assign tick = cnt_q >= period_i - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      left_q <= BIT_CW'(FRAME_W);
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tick) begin
        cnt_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - BIT_CW'(1);
        if (left_q == BIT_CW'(1)) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = sh_q[0];

  // R3
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_o);
  // R3
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> !tx_o);
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  period_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e          state_q;
  logic               s1_q, s2_q, prev_q;
  logic [DIV_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  sh_q;
  logic               done_q;
  logic               full_tick, half_tick;

  assign full_tick = cnt_q >= period_i - DIV_W'(1);
  assign half_tick = cnt_q >= (period_i >> 1) - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      done_q  <= 1'b0;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      done_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (prev_q && !s2_q) state_q <= RX_START;
        end
        RX_START: begin
          if (half_tick) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= s2_q ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        RX_DATA: begin
          if (full_tick) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
            if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
            else idx_q <= idx_q + IDX_W'(1);
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        RX_STOP: begin
          if (full_tick) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
            if (s2_q) begin
              data_o <= sh_q;
              done_q <= 1'b1;
            end
          end else cnt_q <= cnt_q + DIV_W'(1);
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;

  // R8
  done_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == RX_STOP));
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart #(
  parameter int                  BUS_W     = 32,
  parameter int                  DATA_W    = 8,
  parameter int                  MIN_DIV   = 4,
  parameter logic [BUS_W-1:0]    DIV_RESET = 32'd16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [BUS_W-1:0] div_wdata_i,
  output logic [BUS_W-1:0] div_rdata_o,
  input  logic             dat_we_i,
  input  logic             dat_re_i,
  input  logic [BUS_W-1:0] dat_wdata_i,
  output logic [BUS_W-1:0] dat_rdata_o,
  output logic             dat_wait_o,
  output logic             tx_o,
  input  logic             rx_i
);
  logic [BUS_W-1:0]  div_q, period;
  logic              tx_busy, rx_done;
  logic [DATA_W-1:0] rx_data, rx_byte_q;
  logic              rx_valid_q;
  logic              unused_wdata;

  assign unused_wdata = ^dat_wdata_i[BUS_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= DIV_RESET;
    else if (div_we_i) div_q <= div_wdata_i;
  end

  assign period = (div_q < BUS_W'(MIN_DIV)) ? BUS_W'(MIN_DIV) : div_q;

  mmio_uart_tx #(.DIV_W(BUS_W), .DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period),
    .start_i (dat_we_i),
    .data_i  (dat_wdata_i[DATA_W-1:0]),
    .busy_o  (tx_busy),
    .tx_o    (tx_o)
  );

  mmio_uart_rx #(.DIV_W(BUS_W), .DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period),
    .rx_i    (rx_i),
    .done_o  (rx_done),
    .data_o  (rx_data)
  );

  // new byte wins over a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
    end else if (rx_done) begin
      rx_valid_q <= 1'b1;
      rx_byte_q  <= rx_data;
    end else if (dat_re_i) begin
      rx_valid_q <= 1'b0;
    end
  end

  assign div_rdata_o = div_q;
  assign dat_rdata_o = rx_valid_q ? {{(BUS_W-DATA_W){1'b0}}, rx_byte_q} : '1;
  assign dat_wait_o  = dat_we_i && tx_busy;

  // R1
  div_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> div_rdata_o == $past(div_wdata_i));
  // R4
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_i && !dat_wait_o) |=> tx_busy);
  // R7
  read_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_re_i && !rx_done) |=> dat_rdata_o == '1);
endmodule

// File: tb/mmio_uart_tb.sv
module mmio_uart_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        div_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [31:0] div_wdata = '0, dat_wdata = '0;
  logic [31:0] div_rdata, dat_rdata;
  logic        dat_wait, tx, rx;
  logic        loop_en = 1'b1, rx_drv = 1'b1;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign rx = loop_en ? tx : rx_drv;

  mmio_uart u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .div_we_i(div_we), .div_wdata_i(div_wdata), .div_rdata_o(div_rdata),
    .dat_we_i(dat_we), .dat_re_i(dat_re), .dat_wdata_i(dat_wdata),
    .dat_rdata_o(dat_rdata), .dat_wait_o(dat_wait), .tx_o(tx), .rx_i(rx)
  );

  typedef struct packed { logic [31:0] div; logic [7:0] b; } vec_t;
  localparam vec_t VEC [4] = '{
    '{32'd8,  8'hA5}, '{32'd1, 8'h3C}, '{32'd13, 8'h01}, '{32'd6, 8'h80}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [31:0] d);
    return (d < 4) ? 4 : int'(d);
  endfunction

  task automatic set_div(input logic [31:0] d);
    @(negedge clk); div_we = 1'b1; div_wdata = d;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] b, output int stall);
    stall = 0;
    @(negedge clk); dat_we = 1'b1; dat_wdata = {24'hABCDEF, b}; #1;
    while (dat_wait) begin
      stall++;
      @(negedge clk); #1;
    end
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic read_data(output logic [31:0] v);
    @(negedge clk); dat_re = 1'b1; #1; v = dat_rdata;
    @(negedge clk); dat_re = 1'b0;
  endtask

  // called right after write_data returns (half a clock past the accept edge)
  task automatic decode(input int p, output logic [9:0] f);
    repeat (p / 2) @(negedge clk);
    f[0] = tx;
    for (int k = 1; k < 10; k++) begin
      repeat (p) @(negedge clk);
      f[k] = tx;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop, input int p);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); rx_drv = f[k];
      repeat (p - 1) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
    repeat (4 * p) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [9:0]  f;
    int          st;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 / R6 reset state
    chk("R10 tx idle", {31'b0, tx}, 32'd1);
    chk("R10 div reset", div_rdata, 32'd16);
    chk("R6 empty after reset", dat_rdata, 32'hFFFFFFFF);

    foreach (VEC[i]) begin
      set_div(VEC[i].div);
      chk("R1 div readback", div_rdata, VEC[i].div);
      write_data(VEC[i].b, st);
      decode(eff(VEC[i].div), f);
      chk("R3/R2 tx frame", {22'b0, f}, {22'b0, 1'b1, VEC[i].b, 1'b0});
      repeat (3 * eff(VEC[i].div)) @(negedge clk);
      read_data(v);
      chk("R5 rx byte", v, {24'b0, VEC[i].b});
      read_data(v);
      chk("R7 read consumes", v, 32'hFFFFFFFF);
    end

    // R1 full-width divider
    set_div(32'hDEADBEEF);
    chk("R1 full width", div_rdata, 32'hDEADBEEF);
    set_div(32'd8);

    // R4 stall and R9 overwrite via loopback
    write_data(8'h5A, st);
    write_data(8'hC3, st);
    chk("R4 stall cycles", st, 32'd79);
    decode(8, f);
    chk("R4 second frame", {22'b0, f}, {22'b0, 1'b1, 8'hC3, 1'b0});
    repeat (24) @(negedge clk);
    read_data(v);
    chk("R9 overwrite", v, 32'h000000C3);

    // R8 bad stop bit dropped, then recovery
    loop_en = 1'b0;
    send_rx(8'h55, 1'b0, 8);
    read_data(v);
    chk("R8 low stop dropped", v, 32'hFFFFFFFF);
    send_rx(8'h81, 1'b1, 8);
    read_data(v);
    chk("R8 recovery", v, 32'h00000081);
    read_data(v);
    chk("R7 second read", v, 32'hFFFFFFFF);

    // R10 reset mid-use
    send_rx(8'h22, 1'b1, 8);
    set_div(32'd40);
    rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    chk("R10 div after reset", div_rdata, 32'd16);
    chk("R10 buffer after reset", dat_rdata, 32'hFFFFFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule